// File: doc/BRIEF.md
# Adaptive Compression Cost-Benefit Predictor

This block decides whether a compressed cache should store newly allocated lines in compressed form. Each cache access is presented once, with four facts about it: whether a matching tag exists, where that tag sits in the set's recency stack, whether the line's data is resident, and whether the line is held compressed. The compressed size of every tag in the set comes in as well. From these the block sorts the access into one of five classes. An access is charged to compression when it takes a decompression penalty on a hit that would have hit anyway. It is credited to compression when the hit happens only because compression made room, or when the miss would have been avoided had more lines been compressed.

Credits and charges go into a single signed saturating counter. A credit is weighted by the cost of a memory access and a charge by the cost of a decompression, so the counter's sign tracks whether compression is currently a net gain. While the counter is zero or positive the block asks for compressed allocation, and while it is negative it asks for uncompressed allocation. The replacement stack is kept by the surrounding cache, and this block only reads its order.

Top module: `cmp_adapt_predictor`

## Requirements
- R1: An access sampled with `acc_valid` high yields `cls_vld` high on the next clock edge, with its class on `acc_class`. A cycle with `acc_valid` low yields `cls_vld` low.
- R2: Class codes are 0 unpenalized hit, 1 penalized hit, 2 avoided miss, 3 avoidable miss and 4 unavoidable miss. A hit (tag found and data present) at `stack_pos` below `UNC_WAYS` (position 0 is the most recent) is class 1 when the line is compressed and class 0 otherwise.
- R3: A hit at `stack_pos` of `UNC_WAYS` or more is class 2, whatever its compression state.
- R4: When the tag is found but the data is absent, the access is class 3 if the sum of `csize_vec` entries at positions 0 through `stack_pos` is no more than `UNC_WAYS*LINE_SEGS`. Otherwise it is class 4. The entry for stack position i sits in bits [i*SIZE_W +: SIZE_W].
- R5: When no tag is found, the access is class 4 and the data and compression inputs have no effect.
- R6: Classes 2 and 3 add `INC_AMT` to `pred_level` at the same edge that presents the class.
- R7: Class 1 subtracts `DEC_AMT` from `pred_level`.
- R8: Classes 0 and 4, and cycles with no access, leave `pred_level` unchanged.
- R9: `pred_level` is a two's-complement value `CNT_W` bits wide (19 bits by default). A step that would pass either end stops at the largest or smallest representable value and never wraps.
- R10: `alloc_compress` is 1 exactly when `pred_level` is zero or positive.
- R11: After synchronous reset, `pred_level` is 0, `cls_vld` is 0 and `alloc_compress` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One cache access this cycle |
| tag_found | input | 1 | A matching tag exists in the set |
| data_found | input | 1 | The line's data is resident |
| line_compressed | input | 1 | The matching line is stored compressed |
| stack_pos | input | POS_W | Recency position of the matching tag, 0 = most recent |
| csize_vec | input | NUM_TAGS*SIZE_W | Compressed size in segments for each stack position |
| cls_vld | output | 1 | Classification for the previous cycle's access |
| acc_class | output | 3 | Class code of that access |
| alloc_compress | output | 1 | Allocate new lines compressed |
| pred_level | output | CNT_W | Signed predictor counter |

## Verification
The assertions assume that `stack_pos` always names a real stack position, that each compressed size lies between 1 and `LINE_SEGS`, and that reset is applied before the first access. When `tag_found` is low, they allow `data_found` and `line_compressed` to take any value. The random stimulus draws positions only inside the tag count and sizes only inside the legal range, and it sets the data and compression flags freely, including on tagless accesses. The directed cases drive the counter into both saturation limits, and they place the segment sum exactly at the budget and one segment above it.

// File: rtl/cpred_pkg.sv
`timescale 1ns/1ps
package cpred_pkg;

    typedef enum logic [2:0] {
        AC_UNPEN_HIT        = 3'd0,
        AC_PEN_HIT          = 3'd1,
        AC_AVOIDED_MISS     = 3'd2,
        AC_AVOIDABLE_MISS   = 3'd3,
        AC_UNAVOIDABLE_MISS = 3'd4
    } acc_class_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic tag_found;
        logic data_found;
        logic compressed;
    } probe_t;

    // Direction the predictor moves for a given access class
    function automatic step_e class_step(acc_class_e c);
        case (c)
            AC_AVOIDED_MISS,
            AC_AVOIDABLE_MISS: return STEP_UP;
            AC_PEN_HIT:        return STEP_DOWN;
            default:           return STEP_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/cpred_seg_prefix.sv
`timescale 1ns/1ps
module cpred_seg_prefix #(
    parameter int NUM_TAGS = 8,
    parameter int SIZE_W   = 4,
    parameter int POS_W    = 3,
    parameter int SUM_W    = 7
) (
    input  logic [NUM_TAGS*SIZE_W-1:0] csize_vec,
    input  logic [POS_W-1:0]           pos,
    output logic [SUM_W-1:0]           sum_at_pos
);

    // running[g] = size[0] + ... + size[g]
    logic [SUM_W-1:0] running [NUM_TAGS];

    generate
        for (genvar g = 0; g < NUM_TAGS; g++) begin : g_run
            if (g == 0) begin : g_first
                assign running[g] = SUM_W'(csize_vec[SIZE_W-1:0]);
            end else begin : g_next
                assign running[g] = running[g-1] + SUM_W'(csize_vec[g*SIZE_W +: SIZE_W]);
            end
        end
    endgenerate

    assign sum_at_pos = running[pos];

endmodule

// File: rtl/cpred_classifier.sv
`timescale 1ns/1ps
module cpred_classifier
    import cpred_pkg::*;
#(
    parameter int UNC_WAYS   = 4,
    parameter int POS_W      = 3,
    parameter int SUM_W      = 7,
    parameter int SEG_BUDGET = 32
) (
    input  probe_t           probe,
    input  logic [POS_W-1:0] pos,
    input  logic [SUM_W-1:0] seg_sum,
    output acc_class_e       cls
);

    logic in_unc_region;
    logic fits_budget;

    assign in_unc_region = int'(pos) < UNC_WAYS;
    assign fits_budget   = int'(seg_sum) <= SEG_BUDGET;

    always_comb begin
        if (!probe.tag_found) begin
            cls = AC_UNAVOIDABLE_MISS;
        end else if (probe.data_found) begin
            if (!in_unc_region)
                cls = AC_AVOIDED_MISS;
            else if (probe.compressed)
                cls = AC_PEN_HIT;
            else
                cls = AC_UNPEN_HIT;
        end else begin
            cls = fits_budget ? AC_AVOIDABLE_MISS : AC_UNAVOIDABLE_MISS;
        end
    end

endmodule

// File: rtl/cpred_sat_counter.sv
`timescale 1ns/1ps
module cpred_sat_counter
    import cpred_pkg::*;
#(
    parameter int CNT_W   = 19,
    parameter int INC_AMT = 80,
    parameter int DEC_AMT = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  step_e                   step,
    output logic signed [CNT_W-1:0] level
);

    localparam int EW = CNT_W + 1;
    localparam logic signed [EW-1:0] MAX_V = {2'b00, {(CNT_W-1){1'b1}}};
    localparam logic signed [EW-1:0] MIN_V = {2'b11, {(CNT_W-1){1'b0}}};
    localparam logic signed [EW-1:0] INC_V = EW'(INC_AMT);
    localparam logic signed [EW-1:0] DEC_V = EW'(DEC_AMT);

    logic signed [EW-1:0] wide_cur;
    logic signed [EW-1:0] wide_up;
    logic signed [EW-1:0] wide_dn;
    logic signed [CNT_W-1:0] level_nxt;

    assign wide_cur = {level[CNT_W-1], level};
    assign wide_up  = wide_cur + INC_V;
    assign wide_dn  = wide_cur - DEC_V;

    always_comb begin
        level_nxt = level;
        if (en) begin
            case (step)
                STEP_UP:   level_nxt = (wide_up > MAX_V) ? MAX_V[CNT_W-1:0] : wide_up[CNT_W-1:0];
                STEP_DOWN: level_nxt = (wide_dn < MIN_V) ? MIN_V[CNT_W-1:0] : wide_dn[CNT_W-1:0];
                default:   level_nxt = level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level <= '0;
        else     level <= level_nxt;
    end

endmodule

// File: rtl/cmp_adapt_predictor.sv
`timescale 1ns/1ps
module cmp_adapt_predictor
    import cpred_pkg::*;
#(
    parameter  int NUM_TAGS   = 8,
    parameter  int UNC_WAYS   = 4,
    parameter  int LINE_SEGS  = 8,
    parameter  int CNT_W      = 19,
    parameter  int INC_AMT    = 80,
    parameter  int DEC_AMT    = 1,
    localparam int POS_W      = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
    localparam int SIZE_W     = $clog2(LINE_SEGS + 1),
    localparam int SEG_BUDGET = UNC_WAYS * LINE_SEGS,
    localparam int SUM_W      = $clog2(NUM_TAGS * ((1 << SIZE_W) - 1) + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acc_valid,
    input  logic                       tag_found,
    input  logic                       data_found,
    input  logic                       line_compressed,
    input  logic [POS_W-1:0]           stack_pos,
    input  logic [NUM_TAGS*SIZE_W-1:0] csize_vec,
    output logic                       cls_vld,
    output logic [2:0]                 acc_class,
    output logic                       alloc_compress,
    output logic signed [CNT_W-1:0]    pred_level
);

    probe_t          probe;
    logic [SUM_W-1:0] seg_sum;
    acc_class_e      cls_now;
    acc_class_e      cls_q;

    assign probe = '{tag_found: tag_found, data_found: data_found, compressed: line_compressed};

    cpred_seg_prefix #(
        .NUM_TAGS (NUM_TAGS),
        .SIZE_W   (SIZE_W),
        .POS_W    (POS_W),
        .SUM_W    (SUM_W)
    ) u_prefix (
        .csize_vec  (csize_vec),
        .pos        (stack_pos),
        .sum_at_pos (seg_sum)
    );

    cpred_classifier #(
        .UNC_WAYS   (UNC_WAYS),
        .POS_W      (POS_W),
        .SUM_W      (SUM_W),
        .SEG_BUDGET (SEG_BUDGET)
    ) u_class (
        .probe   (probe),
        .pos     (stack_pos),
        .seg_sum (seg_sum),
        .cls     (cls_now)
    );

    cpred_sat_counter #(
        .CNT_W   (CNT_W),
        .INC_AMT (INC_AMT),
        .DEC_AMT (DEC_AMT)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (acc_valid),
        .step  (class_step(cls_now)),
        .level (pred_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_vld <= 1'b0;
            cls_q   <= AC_UNPEN_HIT;
        end else begin
            cls_vld <= acc_valid;
            if (acc_valid) cls_q <= cls_now;
        end
    end

    assign acc_class      = cls_q;
    assign alloc_compress = ~pred_level[CNT_W-1];

endmodule

// File: rtl/cpred_checker.sv
`timescale 1ns/1ps
module cpred_checker #(
    parameter int CNT_W = 19
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    acc_valid,
    input logic                    cls_vld,
    input logic [2:0]              acc_class,
    input logic signed [CNT_W-1:0] pred_level
);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (pred_level == '0 && !cls_vld));

    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> cls_vld);

    // R1
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !cls_vld);

    // R2
    class_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cls_vld |-> (acc_class <= 3'd4));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cls_vld) |-> $stable(pred_level));

    // R8
    neutral_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cls_vld && (acc_class == 3'd0 || acc_class == 3'd4)) |-> $stable(pred_level));

    // R6
    credit_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cls_vld && (acc_class == 3'd2 || acc_class == 3'd3)) |-> (pred_level >= $past(pred_level)));

    // R7
    charge_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cls_vld && acc_class == 3'd1) |-> (pred_level <= $past(pred_level)));

endmodule

bind cmp_adapt_predictor cpred_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .cls_vld    (cls_vld),
    .acc_class  (acc_class),
    .pred_level (pred_level)
);

// File: tb/sim_cmp_adapt_predictor.sv
`timescale 1ns/1ps
module sim_cmp_adapt_predictor;

    localparam int  NT   = 8;
    localparam int  UW   = 4;
    localparam int  LS   = 8;
    localparam int  CW   = 12;
    localparam int  INC  = 80;
    localparam int  DEC  = 3;
    localparam int  SW   = 4;
    localparam int  BUD  = UW * LS;
    localparam longint MAXL = (longint'(1) <<< (CW - 1)) - 1;
    localparam longint MINL = -(longint'(1) <<< (CW - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0;
    logic tag_found = 1'b0;
    logic data_found = 1'b0;
    logic line_compressed = 1'b0;
    logic [2:0] stack_pos = '0;
    logic [NT*SW-1:0] csize_vec = '0;
    logic cls_vld;
    logic [2:0] acc_class;
    logic alloc_compress;
    logic signed [CW-1:0] pred_level;

    int n_chk = 0;
    int n_err = 0;
    longint ref_lvl = 0;
    int sz [NT];

    always #2 clk = ~clk;

    cmp_adapt_predictor #(
        .NUM_TAGS (NT), .UNC_WAYS (UW), .LINE_SEGS (LS),
        .CNT_W (CW), .INC_AMT (INC), .DEC_AMT (DEC)
    ) u0 (
        .clk (clk), .rst (rst), .acc_valid (acc_valid),
        .tag_found (tag_found), .data_found (data_found),
        .line_compressed (line_compressed), .stack_pos (stack_pos),
        .csize_vec (csize_vec), .cls_vld (cls_vld), .acc_class (acc_class),
        .alloc_compress (alloc_compress), .pred_level (pred_level)
    );

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_class(bit th, bit dp, bit cp, int pos);
        int s;
        if (!th) return 4;
        if (dp) begin
            if (pos < UW) return cp ? 1 : 0;
            return 2;
        end
        s = 0;
        for (int i = 0; i <= pos; i++) s += sz[i];
        return (s <= BUD) ? 3 : 4;
    endfunction

    task automatic load_sizes();
        for (int i = 0; i < NT; i++) csize_vec[i*SW +: SW] = SW'(sz[i]);
    endtask

    task automatic access(bit th, bit dp, bit cp, int pos);
        int ec;
        string rq;
        bit clamped;
        longint nxt;
        ec = exp_class(th, dp, cp, pos);
        load_sizes();
        tag_found = th; data_found = dp; line_compressed = cp;
        stack_pos = 3'(pos); acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        nxt = ref_lvl;
        if (ec == 2 || ec == 3) nxt = ref_lvl + INC;
        else if (ec == 1) nxt = ref_lvl - DEC;
        clamped = 1'b0;
        if (nxt > MAXL) begin nxt = MAXL; clamped = 1'b1; end
        if (nxt < MINL) begin nxt = MINL; clamped = 1'b1; end
        ref_lvl = nxt;
        if (!th) rq = "R5";
        else if (ec <= 1) rq = "R2";
        else if (ec == 2) rq = "R3";
        else rq = "R4";
        chk("R1", longint'(cls_vld), 1);
        chk(rq, longint'(acc_class), longint'(ec));
        if (clamped) chk("R9", longint'(pred_level), ref_lvl);
        else if (ec == 1) chk("R7", longint'(pred_level), ref_lvl);
        else if (ec >= 2 && ec <= 3) chk("R6", longint'(pred_level), ref_lvl);
        else chk("R8", longint'(pred_level), ref_lvl);
        chk("R10", longint'(alloc_compress), (ref_lvl >= 0) ? 1 : 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        for (int i = 0; i < NT; i++) sz[i] = 4;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", longint'(pred_level), 0);
        chk("R11", longint'(cls_vld), 0);
        chk("R11", longint'(alloc_compress), 1);

        // R2 unpenalized and penalized hits in the uncompressed region
        access(1, 1, 0, 0);
        access(1, 1, 1, 3);
        // R10 counter now negative
        // R3 avoided miss, compression flag irrelevant
        access(1, 1, 0, 4);
        access(1, 1, 1, 7);
        // R4 budget boundary: 8 entries of 4 -> exactly 32 at position 7
        access(1, 0, 0, 7);
        sz[7] = 5;
        access(1, 0, 1, 7);
        for (int i = 0; i < NT; i++) sz[i] = 8;
        access(1, 0, 0, 3);
        access(1, 0, 0, 4);
        // R5 no tag with data and compression set
        access(0, 1, 1, 0);
        access(0, 0, 1, 5);

        // R8 idle cycles leave the counter alone
        @(negedge clk);
        chk("R1", longint'(cls_vld), 0);
        chk("R8", longint'(pred_level), ref_lvl);

        // R9 upper clamp
        repeat (30) access(1, 1, 0, 5);
        chk("R9", longint'(pred_level), MAXL);
        // R9 lower clamp
        repeat (1400) access(1, 1, 1, 1);
        chk("R9", longint'(pred_level), MINL);
        chk("R10", longint'(alloc_compress), 0);
        access(1, 1, 0, 6);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NT; i++) sz[i] = 1 + int'($urandom % LS);
            access(bit'($urandom % 4 != 0), bit'($urandom % 2), bit'($urandom % 2),
                   int'($urandom % NT));
        end

        summary();
        $finish;
    end

endmodule